// File: doc/BRIEF.md
# Shared PCI Interrupt Line Router

This block takes four shared PCI interrupt request lines and routes each of them onto one of sixteen legacy interrupt-controller inputs. Every shared line has a byte-wide route register, written through a byte-addressed configuration write port. A route value below sixteen selects an output line. Any value of sixteen or more leaves that shared line unconnected. Several shared lines may land on the same output, and that output is then the wired-OR of their levels.

Internally the block keeps a level map with one bit per output line and shared line, at index `line*4 + pirq`. A change on one shared input updates only the bit under that input's current route. A write that hits any route register clears the whole map and rebuilds it from the present level of all four inputs under the new routes. Outputs and the route-change pulse are registered.

Two small combinational helpers complete the block. A slot swizzle turns a device/function number and an INTx pin into a shared-line index. A query port reports, for any shared line, whether its route is enabled and which output it uses.

Top module: `intx_router`

## Requirements
- R1: While reset is held, all four route registers hold 0x80, `irq_out` is all zero, `route_chg` is 0 and the query port reports every route as disabled.
- R2: A write with `cfg_we`=1 to byte address 0x60+p (p = 0..3 for shared lines A..D) stores `cfg_wdata` in route register p from the next clock edge. The query port then shows the new value.
- R3: A route value of 16 or more keeps that shared line off every output, whatever its level.
- R4: One clock edge after the inputs are sampled, `irq_out[l]` is 1 exactly when some shared line with level 1 has an enabled route equal to l.
- R5: A level change on one shared line alters only the output line it is routed to. All other outputs keep their values.
- R6: A route write rebuilds the outputs from the present levels with the new routes, in the same cycle as the write. The old line drops and the new line rises together one edge later.
- R7: Writes to addresses outside 0x60..0x63 change no route register, and `route_chg` is not pulsed.
- R8: `route_chg` is 1 for exactly the one cycle that follows each write hitting a route register.
- R9: `swz_pirq` = (`swz_pin` + `swz_devfn[7:3]` - 1) mod 4, combinationally. Device number 0 wraps to pin-1 mod 4.
- R10: The query port gives `qry_en` = 1 when the route of shared line `qry_sel` is below 16. It gives `qry_line` = that route's low four bits.
- R11: When two enabled shared lines are routed to one output, that output stays 1 until both levels are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| pirq_lvl | input | 4 | Present level of shared lines A..D (bit 0 = A) |
| swz_devfn | input | 8 | Device/function number for the swizzle |
| swz_pin | input | 2 | INTx pin index 0..3 for the swizzle |
| swz_pirq | output | 2 | Shared-line index from the swizzle |
| qry_sel | input | 2 | Shared line to query |
| qry_en | output | 1 | Selected route is enabled |
| qry_line | output | 4 | Output line of the selected route |
| irq_out | output | 16 | Routed interrupt levels to the controllers |
| route_chg | output | 1 | One-cycle pulse after a route register write |

## Verification
The checker assumes that `pirq_lvl`, `cfg_we`, `cfg_addr` and `cfg_wdata` are settled at each rising edge. It also assumes that the level inputs are true levels that are held for at least one cycle. The stimulus meets both assumptions by changing every input only at the falling edge. Each input pattern is held for a whole cycle. The checker further assumes that a route write and a level change may share a cycle. The stimulus covers this case on purpose by rerouting a shared line while its level is high.

// File: rtl/intx_router_pkg.sv
package intx_router_pkg;

    typedef logic [7:0] route_t;

    localparam route_t ROUTE_RESET = 8'h80;

    // A route selects an output only when it is below the line count.
    function automatic logic route_live(input route_t r, input int num_line);
        return int'(r) < num_line;
    endfunction

endpackage

// File: rtl/intx_route_file.sv
module intx_route_file
    import intx_router_pkg::*;
#(
    parameter int     NUM_PIRQ   = 4,
    parameter route_t ROUTE_BASE = 8'h60
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [7:0]                wr_addr,
    input  logic [7:0]                wr_data,
    output route_t [NUM_PIRQ-1:0]     route_cur,
    output route_t [NUM_PIRQ-1:0]     route_new,
    output logic                      wr_hit,
    output logic                      chg_pulse
);
    localparam int SEL_W = (NUM_PIRQ > 1) ? $clog2(NUM_PIRQ) : 1;

    typedef struct packed {
        route_t [NUM_PIRQ-1:0] route;
        logic                  chg;
    } st_t;

    st_t st_d, st_q;
    logic [7:0]       off;
    logic [SEL_W-1:0] sel;

    always_comb begin
        off    = wr_addr - ROUTE_BASE;
        sel    = off[SEL_W-1:0];
        wr_hit = wr_en && (wr_addr >= ROUTE_BASE) &&
                 (int'(off) < NUM_PIRQ);
        st_d     = st_q;
        st_d.chg = wr_hit;
        if (wr_hit) begin
            st_d.route[sel] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.route <= {NUM_PIRQ{ROUTE_RESET}};
            st_q.chg   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign route_cur = st_q.route;
    assign route_new = st_d.route;
    assign chg_pulse = st_q.chg;

endmodule

// File: rtl/intx_level_map.sv
module intx_level_map
    import intx_router_pkg::*;
#(
    parameter int NUM_PIRQ = 4,
    parameter int NUM_LINE = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_PIRQ-1:0]    level,
    input  route_t [NUM_PIRQ-1:0]  route_cur,
    input  route_t [NUM_PIRQ-1:0]  route_new,
    input  logic                   rebuild,
    output logic [NUM_LINE-1:0]    irq
);
    localparam int LINE_W = $clog2(NUM_LINE);
    localparam int MAP_W  = NUM_LINE * NUM_PIRQ;

    typedef struct packed {
        logic [MAP_W-1:0]    map;
        logic [NUM_PIRQ-1:0] lvl;
        logic [NUM_LINE-1:0] irq;
    } st_t;

    st_t st_d, st_q;

    function automatic int map_idx(input route_t r, input int p);
        return int'(r[LINE_W-1:0]) * NUM_PIRQ + p;
    endfunction

    always_comb begin
        st_d     = st_q;
        st_d.lvl = level;
        if (rebuild) begin
            // Routing changed: start from an empty map, re-place every line.
            st_d.map = '0;
            for (int p = 0; p < NUM_PIRQ; p++) begin
                if (route_live(route_new[p], NUM_LINE)) begin
                    st_d.map[map_idx(route_new[p], p)] = level[p];
                end
            end
        end else begin
            // Only a changed input touches its own bit under its route.
            for (int p = 0; p < NUM_PIRQ; p++) begin
                if ((level[p] != st_q.lvl[p]) &&
                    route_live(route_cur[p], NUM_LINE)) begin
                    st_d.map[map_idx(route_cur[p], p)] = level[p];
                end
            end
        end
        for (int l = 0; l < NUM_LINE; l++) begin
            st_d.irq[l] = |st_d.map[l*NUM_PIRQ +: NUM_PIRQ];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.irq;

endmodule

// File: rtl/intx_swizzle.sv
module intx_swizzle #(
    parameter int NUM_PIRQ = 4
) (
    input  logic [7:0]                         devfn,
    input  logic [$clog2(NUM_PIRQ)-1:0]        pin,
    output logic [$clog2(NUM_PIRQ)-1:0]        pirq
);
    localparam int SEL_W = $clog2(NUM_PIRQ);

    logic [7:0] sum;

    // Adding NUM_PIRQ-1 equals subtracting one modulo a power-of-two count.
    always_comb begin
        sum  = 8'(pin) + 8'(devfn >> 3) + 8'(NUM_PIRQ - 1);
        pirq = sum[SEL_W-1:0];
    end

endmodule

// File: rtl/intx_router.sv
module intx_router
    import intx_router_pkg::*;
#(
    parameter int     NUM_PIRQ   = 4,
    parameter int     NUM_LINE   = 16,
    parameter route_t ROUTE_BASE = 8'h60
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [7:0]                    cfg_addr,
    input  logic [7:0]                    cfg_wdata,
    input  logic [NUM_PIRQ-1:0]           pirq_lvl,
    input  logic [7:0]                    swz_devfn,
    input  logic [$clog2(NUM_PIRQ)-1:0]   swz_pin,
    output logic [$clog2(NUM_PIRQ)-1:0]   swz_pirq,
    input  logic [$clog2(NUM_PIRQ)-1:0]   qry_sel,
    output logic                          qry_en,
    output logic [$clog2(NUM_LINE)-1:0]   qry_line,
    output logic [NUM_LINE-1:0]           irq_out,
    output logic                          route_chg
);
    localparam int LINE_W = $clog2(NUM_LINE);

    route_t [NUM_PIRQ-1:0] route_cur;
    route_t [NUM_PIRQ-1:0] route_new;
    logic                  wr_hit;
    route_t                qry_route;

    intx_route_file #(
        .NUM_PIRQ   (NUM_PIRQ),
        .ROUTE_BASE (ROUTE_BASE)
    ) u_routes (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_addr   (cfg_addr),
        .wr_data   (cfg_wdata),
        .route_cur (route_cur),
        .route_new (route_new),
        .wr_hit    (wr_hit),
        .chg_pulse (route_chg)
    );

    intx_level_map #(
        .NUM_PIRQ (NUM_PIRQ),
        .NUM_LINE (NUM_LINE)
    ) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .level     (pirq_lvl),
        .route_cur (route_cur),
        .route_new (route_new),
        .rebuild   (wr_hit),
        .irq       (irq_out)
    );

    intx_swizzle #(
        .NUM_PIRQ (NUM_PIRQ)
    ) u_swz (
        .devfn (swz_devfn),
        .pin   (swz_pin),
        .pirq  (swz_pirq)
    );

    always_comb begin
        qry_route = route_cur[qry_sel];
        qry_en    = route_live(qry_route, NUM_LINE);
        qry_line  = qry_route[LINE_W-1:0];
    end

endmodule

// File: rtl/intx_router_chk.sv
module intx_router_chk
    import intx_router_pkg::*;
#(
    parameter int     NUM_PIRQ   = 4,
    parameter int     NUM_LINE   = 16,
    parameter route_t ROUTE_BASE = 8'h60
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [7:0]            cfg_addr,
    input  logic [7:0]            cfg_wdata,
    input  logic [NUM_PIRQ-1:0]   pirq_lvl,
    input  route_t [NUM_PIRQ-1:0] route_cur,
    input  logic [NUM_LINE-1:0]   irq_out,
    input  logic                  route_chg
);
    localparam int SEL_W = $clog2(NUM_PIRQ);

    logic                  hit;
    logic [7:0]            off;
    logic [SEL_W-1:0]      sel;
    logic                  all_off;
    logic [NUM_PIRQ-1:0]   lvl_prev;
    logic                  armed;
    logic [NUM_LINE-1:0]   model;

    always_comb begin
        off     = cfg_addr - ROUTE_BASE;
        sel     = off[SEL_W-1:0];
        hit     = cfg_we && (cfg_addr >= ROUTE_BASE) && (int'(off) < NUM_PIRQ);
        all_off = 1'b1;
        model   = '0;
        for (int p = 0; p < NUM_PIRQ; p++) begin
            if (int'(route_cur[p]) < NUM_LINE) begin
                all_off = 1'b0;
                if (lvl_prev[p]) model[int'(route_cur[p]) % NUM_LINE] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_prev <= '0;
            armed    <= 1'b0;
        end else begin
            lvl_prev <= pirq_lvl;
            armed    <= 1'b1;
        end
    end

    a_r8_pulse_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> route_chg);

    a_r7_no_pulse_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> !route_chg);

    a_r2_route_stored: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (route_cur[$past(sel)] == $past(cfg_wdata)));

    a_r3_all_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (all_off && !hit) |=> (irq_out == '0));

    a_r4_or_of_routed: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (irq_out == model));

endmodule

bind intx_router intx_router_chk #(
    .NUM_PIRQ   (NUM_PIRQ),
    .NUM_LINE   (NUM_LINE),
    .ROUTE_BASE (ROUTE_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .pirq_lvl  (pirq_lvl),
    .route_cur (route_cur),
    .irq_out   (irq_out),
    .route_chg (route_chg)
);

// File: tb/sim_intx_router.sv
module sim_intx_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [3:0]  pirq_lvl = 4'h0;
    logic [7:0]  swz_devfn = 8'h00;
    logic [1:0]  swz_pin = 2'd0;
    logic [1:0]  swz_pirq;
    logic [1:0]  qry_sel = 2'd0;
    logic        qry_en;
    logic [3:0]  qry_line;
    logic [15:0] irq_out;
    logic        route_chg;

    int n_vec = 0;
    int n_bad = 0;
    int bm_route [4] = '{8'h80, 8'h80, 8'h80, 8'h80};
    logic [3:0] cur_lvl = 4'h0;
    bit done = 1'b0;

    typedef struct {
        logic [15:0] irq;
        logic        chg;
        string       tag;
    } item_t;

    item_t sb [$];

    always #10 clk = ~clk;

    intx_router u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .pirq_lvl  (pirq_lvl),
        .swz_devfn (swz_devfn),
        .swz_pin   (swz_pin),
        .swz_pirq  (swz_pirq),
        .qry_sel   (qry_sel),
        .qry_en    (qry_en),
        .qry_line  (qry_line),
        .irq_out   (irq_out),
        .route_chg (route_chg)
    );

    task automatic check(input logic ok, input string tag, input string what,
                         input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and push the expected result.
    task automatic step(input logic [3:0] lvl, input logic we, input logic [7:0] a,
                        input logic [7:0] d, input string tag);
        item_t it;
        logic  hit;
        @(negedge clk);
        pirq_lvl  = lvl;
        cfg_we    = we;
        cfg_addr  = a;
        cfg_wdata = d;
        cur_lvl   = lvl;
        hit = we && (a >= 8'h60) && (a <= 8'h63);
        if (hit) bm_route[a - 8'h60] = int'(d);
        it.irq = '0;
        for (int p = 0; p < 4; p++) begin
            if (lvl[p] && bm_route[p] < 16) it.irq[bm_route[p]] = 1'b1;
        end
        it.chg = hit;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle(input string tag);
        step(cur_lvl, 1'b0, 8'h00, 8'h00, tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
        step(cur_lvl, 1'b1, a, d, tag);
    endtask

    // Query check: idle cycle, then look at the combinational query port.
    task automatic query(input logic [1:0] sel, input string tag);
        idle(tag);
        qry_sel = sel;
        #1;
        check(qry_en == (bm_route[sel] < 16), tag, "qry_en", int'(qry_en),
              int'(bm_route[sel] < 16));
        check(qry_line == 4'(bm_route[sel]), tag, "qry_line", int'(qry_line),
              bm_route[sel] % 16);
    endtask

    // Monitor: compare each registered result after the edge that made it.
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                check(irq_out == it.irq, it.tag, "irq_out", int'(irq_out), int'(it.irq));
                check(route_chg == it.chg, (it.chg || it.tag == "R7") ? "R8" : it.tag,
                      "route_chg", int'(route_chg), int'(it.chg));
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state, observed while reset is held
        repeat (3) @(negedge clk);
        check(irq_out == 16'h0, "R1", "irq_out", int'(irq_out), 0);
        check(route_chg == 1'b0, "R1", "route_chg", int'(route_chg), 0);
        for (int s = 0; s < 4; s++) begin
            qry_sel = 2'(s);
            #1;
            check(qry_en == 1'b0, "R1", "qry_en", int'(qry_en), 0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        idle("R1");
        idle("R1");

        // R3: every route disabled, all inputs high
        step(4'hF, 1'b0, 8'h00, 8'h00, "R3");
        idle("R3");

        // R2/R6: route A to line 5 while A is high
        wr(8'h60, 8'h05, "R6");
        query(2'd0, "R10");
        query(2'd0, "R2");

        // R11: B shares line 5; C to 10; D disabled with 0x10
        wr(8'h61, 8'h05, "R11");
        wr(8'h62, 8'h0A, "R2");
        wr(8'h63, 8'h10, "R3");
        query(2'd3, "R10");
        query(2'd2, "R10");

        // R11: drop A, line 5 held by B; then drop B
        step(4'hE, 1'b0, 8'h00, 8'h00, "R11");
        step(4'hC, 1'b0, 8'h00, 8'h00, "R4");
        // R5: toggle C only, line 10 alone moves
        step(4'h8, 1'b0, 8'h00, 8'h00, "R5");
        step(4'hC, 1'b0, 8'h00, 8'h00, "R5");

        // R7: writes beside the route window
        wr(8'h5F, 8'h01, "R7");
        wr(8'h64, 8'h02, "R7");
        wr(8'h00, 8'h03, "R7");
        query(2'd0, "R7");
        query(2'd3, "R7");

        // R6: reroute C from 10 to 3 while high
        wr(8'h62, 8'h03, "R6");
        idle("R6");
        // enable D on line 15
        wr(8'h63, 8'h0F, "R2");
        query(2'd3, "R10");

        // R4: sweep all level patterns
        for (int i = 0; i < 16; i++) begin
            step(4'(i), 1'b0, 8'h00, 8'h00, "R4");
        end
        // R4/R6: level change in the same cycle as a route write
        step(4'h3, 1'b1, 8'h61, 8'h07, "R6");
        step(4'h1, 1'b0, 8'h00, 8'h00, "R5");

        // R3: disable with 0xFF while high
        step(4'hF, 1'b0, 8'h00, 8'h00, "R4");
        wr(8'h60, 8'hFF, "R3");
        wr(8'h63, 8'h20, "R3");
        query(2'd0, "R3");
        idle("R3");
        idle("R3");

        // R9: swizzle over device numbers and pins, function bits varied
        for (int dv = 0; dv < 8; dv++) begin
            for (int pn = 0; pn < 4; pn++) begin
                swz_devfn = 8'((dv << 3) | ((dv + pn) & 7));
                swz_pin   = 2'(pn);
                #1;
                check(swz_pirq == 2'((pn + dv + 3) & 3), "R9", "swz_pirq",
                      int'(swz_pirq), (pn + dv + 3) & 3);
            end
        end

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule